// File: doc/BRIEF.md
# SDRAM Module Configuration Boot Sequencer

This block brings up an external SDRAM module with no software involved. After a start pulse it reads the module's serial description bytes through a simple byte-read request/response port, which stands for a two-wire serial bus controller. It first works out the module clock speed. It then fetches the geometry and timing bytes and packs them into a 32-bit module control word. Next it programs the global SDRAM control word, adding ECC when the module type calls for it. Finally it starts the memory initialisation and polls a busy flag until the controller finishes. It reports the detected speed, the module size in megabytes, and a done or error flag.

The sequence is a single enumerated state machine. From `S_IDLE`, a start pulse moves it to `S_DET_FREQ`, which reads the frequency byte. It then goes either to `S_DET_CLK`, which reads the cycle-time byte, or straight to `S_RD_TBL`. `S_RD_TBL` makes twelve table reads. After the table come the write states, always in this order: `S_WR_MOD`, `S_WR_GDEF`, then `S_WR_GECC` only for ECC modules, then `S_WR_GINIT`. The machine then enters `S_POLL` and ends in `S_DONE` or `S_FAIL`. The moves into `S_FAIL` are these:
- a read that is not acknowledged;
- a cycle-time byte that is too slow;
- a poll that times out.

A start pulse re-arms the machine from `S_DONE` or `S_FAIL`. The combinational packer uses three constant divide-by-ten units for the rounding of the timing fields.

Top module: `sdram_spd_boot`

## Requirements
- R1: After start the first read targets device `DEV_ADDR` (default 0x50), byte 126. If it returns 100, `speed_mhz` becomes 100 and byte 9 is not read.
- R2: Otherwise byte 9 is read. A value of at most 0x75 gives `speed_mhz` = 133. A larger value ends in error with no write on the configuration port.
- R3: Any read answered with `rd_ok`=0 ends the sequence in error. No configuration write follows.
- R4: The twelve module bytes are read in the order 11, 12, 4, 21, 3, 17, 5, 27, 28, 29, 30, 18.
- R5: In the module word, bits 2:0 hold (b4−8). Bit 3 is always 1. Bits 5:4 hold (b3−11). Bit 6 is bit 0 of b17/4. Bit 7 is bit 0 of b5/2. Bits 31:23 are 0. Every field is truncated to its width.
- R6: Bits 9:8 hold ceil(b27/10)−1. Bits 11:10 hold ceil(max(b28,b29)/10)−1. Bits 13:12 hold ceil(((b30−b29) mod 256)/10)−2. Each ceiling is computed as (x+9)/10, and each result is truncated to 2 bits.
- R7: Bits 15:14 are 3 if bit 3 of b18 is set. Otherwise they are 2 if bit 2 is set, 1 if bit 0 is set, and 0 if none of these is set.
- R8: The size exponent is e = b4 + b5/2 + b3 + b17/2 + 3. `size_mb` is 2^(e−20), or 0 when e < 20. Bits 22:16 of the module word hold (size_mb/16 − 1) mod 128.
- R9: The writes come in a fixed order:
  - the module word, with `cfg_sel_glb`=0;
  - the global word 0x022259F1;
  - 0x022359F1 (ECC bit 16 set), only when b11 equals 2;
  - the init word, which is the last global value with bit 18 cleared and bit 19 set (0x022A59F1, or 0x022B59F1 with ECC).

  All global writes have `cfg_sel_glb`=1.
- R10: After the init write the sequencer samples `init_busy` once per cycle. It ends in done when `init_busy` is low. It ends in error after `TIMEOUT_CYC` consecutive high samples.
- R11: `done` and `error` stay high until the next start. A start pulse while a sequence is running has no effect.
- R12: `rd_req` stays high, with `rd_dev` and `rd_sub` stable, until the cycle in which `rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration sequence |
| rd_req | output | 1 | Byte-read request |
| rd_dev | output | 7 | Target device address |
| rd_sub | output | 8 | Byte index within the device |
| rd_ack | input | 1 | Read finished (one-cycle pulse) |
| rd_ok | input | 1 | Read was acknowledged by the device (valid with rd_ack) |
| rd_data | input | 8 | Byte returned (valid with rd_ack) |
| cfg_wr | output | 1 | Configuration register write strobe |
| cfg_sel_glb | output | 1 | 0 = module control word, 1 = global control word |
| cfg_wdata | output | 32 | Value written |
| init_busy | input | 1 | Bit 19 of the global word as seen in the controller (initialisation running) |
| speed_mhz | output | 8 | Detected speed (0, 100 or 133) |
| size_mb | output | 16 | Module size in megabytes |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence failed |

## Verification
The assertions take certain properties of the read port for granted:
- `rd_ack` is a single-cycle pulse that comes only while `rd_req` is high;
- `init_busy` shows the controller's view of the init bit, so it only falls after the init write.

The bench's responder keeps to this. It answers one request at a time after a random 0–3 cycle delay and drops `rd_ack` on the following cycle. The busy model raises the flag in the cycle of the init write and lowers it after a bounded random delay, except in the timeout case. Random module bytes are drawn inside the ranges where the arithmetic fields are meaningful. Directed cases then reach each CAS priority level, the byte-9 limit, sizes below 16 MB and reads that fail.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DET_FREQ,
        S_DET_CLK,
        S_RD_TBL,
        S_WR_MOD,
        S_WR_GDEF,
        S_WR_GECC,
        S_WR_GINIT,
        S_POLL,
        S_DONE,
        S_FAIL
    } seq_state_t;

    // Module bytes kept for the control word (type byte held separately)
    typedef struct packed {
        logic [7:0] row_bits;   // byte 3
        logic [7:0] col_bits;   // byte 4
        logic [7:0] mod_rows;   // byte 5
        logic [7:0] banks;      // byte 17
        logic [7:0] cas_map;    // byte 18
        logic [7:0] attr;       // byte 21
        logic [7:0] t_rp;       // byte 27
        logic [7:0] t_rrd;      // byte 28
        logic [7:0] t_rcd;      // byte 29
        logic [7:0] t_ras;      // byte 30
    } spd_bytes_t;

    localparam logic [7:0]  SUB_FREQ      = 8'd126;
    localparam logic [7:0]  SUB_CYCLE     = 8'd9;
    localparam logic [7:0]  FREQ_100      = 8'd100;
    localparam logic [7:0]  CYCLE_LIMIT   = 8'h75;
    localparam logic [7:0]  TYPE_ECC      = 8'd2;
    localparam int          TBL_LEN       = 12;
    localparam int          IDX_W         = $clog2(TBL_LEN);
    localparam logic [31:0] GLB_DEFAULT   = 32'h0222_59F1;
    localparam int          GLB_ECC_BIT   = 16;
    localparam int          GLB_ISEL_BIT  = 18;
    localparam int          GLB_IGO_BIT   = 19;

    // Byte index fetched at each table step; order matters to the capture
    function automatic logic [7:0] tbl_sub(input logic [IDX_W-1:0] idx);
        logic [7:0] s;
        unique case (idx)
            4'd0:    s = 8'd11;
            4'd1:    s = 8'd12;
            4'd2:    s = 8'd4;
            4'd3:    s = 8'd21;
            4'd4:    s = 8'd3;
            4'd5:    s = 8'd17;
            4'd6:    s = 8'd5;
            4'd7:    s = 8'd27;
            4'd8:    s = 8'd28;
            4'd9:    s = 8'd29;
            4'd10:   s = 8'd30;
            default: s = 8'd18;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdcfg_ceil_div10.sv
module sdcfg_ceil_div10 (
    input  logic [7:0] num,
    output logic [4:0] quo
);
    logic [8:0] biased;

    always_comb begin
        biased = {1'b0, num} + 9'd9;
        quo    = 5'(biased / 9'd10);
    end
endmodule

// File: rtl/sdcfg_word_pack.sv
module sdcfg_word_pack
    import sdcfg_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  spd_bytes_t        spd,
    output logic [31:0]       mod_word,
    output logic [SIZE_W-1:0] size_mb
);
    localparam int N_DIV = 3;

    logic [7:0] div_in [N_DIV];
    logic [4:0] div_q  [N_DIV];
    logic [7:0] t_max;

    always_comb begin
        t_max     = (spd.t_rcd > spd.t_rrd) ? spd.t_rcd : spd.t_rrd;
        div_in[0] = spd.t_rp;
        div_in[1] = t_max;
        div_in[2] = spd.t_ras - spd.t_rcd;
    end

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        sdcfg_ceil_div10 u_div (
            .num (div_in[g]),
            .quo (div_q[g])
        );
    end

    function automatic logic [1:0] cas_code(input logic [7:0] m);
        logic [1:0] c;
        if (m[3])      c = 2'd3;
        else if (m[2]) c = 2'd2;
        else if (m[0]) c = 2'd1;
        else           c = 2'd0;
        return c;
    endfunction

    logic [9:0] expo;
    logic [9:0] shamt;
    logic [2:0] col_f;
    logic [1:0] row_f;
    logic       attr_b;
    logic [1:0] trp_f, tmax_f, tras_f, cas_f;
    logic [4:0] trp_m1, tmax_m1, tras_m2;
    logic [6:0] size_f;

    always_comb begin
        expo  = 10'(spd.col_bits) + 10'(spd.mod_rows >> 1) + 10'(spd.row_bits)
              + 10'(spd.banks >> 1) + 10'd3;
        shamt = expo - 10'd20;
        if (expo >= 10'd20 && shamt < 10'(SIZE_W))
            size_mb = SIZE_W'(1) << shamt;
        else
            size_mb = '0;

        col_f   = 3'(spd.col_bits - 8'd8);
        row_f   = 2'(spd.row_bits - 8'd11);
        attr_b  = (spd.attr != 8'd0) | 1'b1;   // field forced on
        trp_m1  = div_q[0] - 5'd1;
        tmax_m1 = div_q[1] - 5'd1;
        tras_m2 = div_q[2] - 5'd2;
        trp_f   = trp_m1[1:0];
        tmax_f  = tmax_m1[1:0];
        tras_f  = tras_m2[1:0];
        cas_f   = cas_code(spd.cas_map);
        size_f  = size_mb[10:4] - 7'd1;

        mod_word = {8'h00, 1'b0, size_f, cas_f, tras_f, tmax_f, trp_f,
                    spd.mod_rows[1], spd.banks[2], row_f, attr_b, col_f};
    end
endmodule

// File: rtl/sdram_spd_boot.sv
module sdram_spd_boot
    import sdcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         TIMEOUT_CYC = 1000,
    parameter int         SIZE_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_req,
    output logic [6:0]        rd_dev,
    output logic [7:0]        rd_sub,
    input  logic              rd_ack,
    input  logic              rd_ok,
    input  logic [7:0]        rd_data,
    output logic              cfg_wr,
    output logic              cfg_sel_glb,
    output logic [31:0]       cfg_wdata,
    input  logic              init_busy,
    output logic [7:0]        speed_mhz,
    output logic [SIZE_W-1:0] size_mb,
    output logic              done,
    output logic              error
);
    localparam int             CNT_W    = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TBL_LEN - 1);

    seq_state_t          state, state_nx;
    logic [IDX_W-1:0]    tbl_idx;
    logic [CNT_W-1:0]    poll_cnt;
    logic [7:0]          speed_q;
    logic [SIZE_W-1:0]   size_q;
    spd_bytes_t          spd_q;
    logic [7:0]          mem_type_q;
    logic [31:0]         pack_word;
    logic [SIZE_W-1:0]   pack_size;
    logic                ecc_en;
    logic [31:0]         glb_base;

    sdcfg_word_pack #(.SIZE_W(SIZE_W)) u_pack (
        .spd      (spd_q),
        .mod_word (pack_word),
        .size_mb  (pack_size)
    );

    assign ecc_en   = (mem_type_q == TYPE_ECC);
    assign glb_base = ecc_en ? (GLB_DEFAULT | (32'd1 << GLB_ECC_BIT)) : GLB_DEFAULT;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_DONE, S_FAIL:
                if (start) state_nx = S_DET_FREQ;
            S_DET_FREQ:
                if (rd_ack) begin
                    if (!rd_ok)                  state_nx = S_FAIL;
                    else if (rd_data == FREQ_100) state_nx = S_RD_TBL;
                    else                         state_nx = S_DET_CLK;
                end
            S_DET_CLK:
                if (rd_ack) begin
                    if (rd_ok && rd_data <= CYCLE_LIMIT) state_nx = S_RD_TBL;
                    else                                 state_nx = S_FAIL;
                end
            S_RD_TBL:
                if (rd_ack) begin
                    if (!rd_ok)                 state_nx = S_FAIL;
                    else if (tbl_idx == IDX_LAST) state_nx = S_WR_MOD;
                end
            S_WR_MOD:   state_nx = S_WR_GDEF;
            S_WR_GDEF:  state_nx = ecc_en ? S_WR_GECC : S_WR_GINIT;
            S_WR_GECC:  state_nx = S_WR_GINIT;
            S_WR_GINIT: state_nx = S_POLL;
            S_POLL:
                if (!init_busy)              state_nx = S_DONE;
                else if (poll_cnt == POLL_LAST) state_nx = S_FAIL;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Captured bytes, counters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_idx    <= '0;
            poll_cnt   <= '0;
            speed_q    <= '0;
            size_q     <= '0;
            spd_q      <= '0;
            mem_type_q <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE, S_FAIL:
                    if (start) begin
                        tbl_idx <= '0;
                        speed_q <= '0;
                        size_q  <= '0;
                    end
                S_DET_FREQ:
                    if (rd_ack && rd_ok && rd_data == FREQ_100) speed_q <= 8'd100;
                S_DET_CLK:
                    if (rd_ack && rd_ok && rd_data <= CYCLE_LIMIT) speed_q <= 8'd133;
                S_RD_TBL:
                    if (rd_ack && rd_ok) begin
                        tbl_idx <= tbl_idx + 1'b1;
                        unique case (tbl_idx)
                            4'd0:    mem_type_q     <= rd_data;
                            4'd1:    ;  // refresh byte is fetched but not used
                            4'd2:    spd_q.col_bits <= rd_data;
                            4'd3:    spd_q.attr     <= rd_data;
                            4'd4:    spd_q.row_bits <= rd_data;
                            4'd5:    spd_q.banks    <= rd_data;
                            4'd6:    spd_q.mod_rows <= rd_data;
                            4'd7:    spd_q.t_rp     <= rd_data;
                            4'd8:    spd_q.t_rrd    <= rd_data;
                            4'd9:    spd_q.t_rcd    <= rd_data;
                            4'd10:   spd_q.t_ras    <= rd_data;
                            default: spd_q.cas_map  <= rd_data;
                        endcase
                    end
                S_WR_MOD:   size_q   <= pack_size;
                S_WR_GINIT: poll_cnt <= '0;
                S_POLL:
                    if (init_busy && poll_cnt != POLL_LAST) poll_cnt <= poll_cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req      = 1'b0;
        rd_dev      = DEV_ADDR;
        rd_sub      = 8'd0;
        cfg_wr      = 1'b0;
        cfg_sel_glb = 1'b1;
        cfg_wdata   = 32'd0;
        unique case (state)
            S_DET_FREQ: begin rd_req = 1'b1; rd_sub = SUB_FREQ;          end
            S_DET_CLK:  begin rd_req = 1'b1; rd_sub = SUB_CYCLE;         end
            S_RD_TBL:   begin rd_req = 1'b1; rd_sub = tbl_sub(tbl_idx);  end
            S_WR_MOD:   begin cfg_wr = 1'b1; cfg_sel_glb = 1'b0; cfg_wdata = pack_word; end
            S_WR_GDEF:  begin cfg_wr = 1'b1; cfg_wdata = GLB_DEFAULT; end
            S_WR_GECC:  begin cfg_wr = 1'b1; cfg_wdata = glb_base;    end
            S_WR_GINIT: begin
                cfg_wr    = 1'b1;
                cfg_wdata = (glb_base & ~(32'd1 << GLB_ISEL_BIT)) | (32'd1 << GLB_IGO_BIT);
            end
            default: ;
        endcase
        done      = (state == S_DONE);
        error     = (state == S_FAIL);
        speed_mhz = speed_q;
        size_mb   = size_q;
    end

    // R12: a pending request keeps its address until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_sub) && $stable(rd_dev));

    // R1 R2: done only ever reports one of the two detected speeds
    p_speed_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (speed_mhz == 8'd100 || speed_mhz == 8'd133));

    // R5: module word fixed bits
    p_mod_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_sel_glb |-> cfg_wdata[3] && cfg_wdata[31:23] == 9'd0);

    // R9: ECC enable only for an ECC module type
    p_ecc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel_glb && cfg_wdata[GLB_ECC_BIT] |-> mem_type_q == TYPE_ECC);

    // R10: completion follows a low busy sample; counter stays within the window
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!init_busy));
    p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_POLL |-> poll_cnt <= POLL_LAST);
endmodule

// File: tb/sdram_spd_boot_bench.sv
`timescale 1ns/1ps
module sdram_spd_boot_bench;
    localparam int TMO = 64;
    localparam int TBL [12] = '{11, 12, 4, 21, 3, 17, 5, 27, 28, 29, 30, 18};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [6:0]  rd_dev;
    logic [7:0]  rd_sub;
    logic        rd_ack = 1'b0;
    logic        rd_ok = 1'b0;
    logic [7:0]  rd_data = 8'd0;
    logic        cfg_wr, cfg_sel_glb;
    logic [31:0] cfg_wdata;
    logic        init_busy = 1'b0;
    logic [7:0]  speed_mhz;
    logic [15:0] size_mb;
    logic        done, error;

    always #2.5 clk = ~clk;

    sdram_spd_boot #(.DEV_ADDR(7'h50), .TIMEOUT_CYC(TMO), .SIZE_W(16)) u_sdram_spd_boot (
        .clk, .rst_n, .start, .rd_req, .rd_dev, .rd_sub, .rd_ack, .rd_ok, .rd_data,
        .cfg_wr, .cfg_sel_glb, .cfg_wdata, .init_busy, .speed_mhz, .size_mb, .done, .error
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0]  spd [128];
    int          nack_sub = -1;
    bit          busy_forever = 0;
    int          rsp_wait = 0;
    int          busy_left = 0;
    logic [7:0]  rd_log [32];
    int          rd_n = 0;
    logic [31:0] wr_data [8];
    logic        wr_sel [8];
    int          wr_n = 0;
    int          dev_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Byte-read responder (R12 handshake: one answer per request)
    always @(negedge clk) begin
        if (rd_ack) rd_ack = 1'b0;
        else if (rd_req) begin
            if (rsp_wait > 0) rsp_wait--;
            else begin
                if (rd_dev != 7'h50) dev_bad++;
                rd_ack  = 1'b1;
                rd_ok   = (int'(rd_sub) != nack_sub);
                rd_data = spd[rd_sub[6:0]];
                if (rd_n < 32) rd_log[rd_n] = rd_sub;
                rd_n++;
                rsp_wait = $urandom_range(0, 3);
            end
        end
    end

    // Write logger and busy model
    always @(negedge clk) begin
        if (cfg_wr) begin
            if (wr_n < 8) begin wr_data[wr_n] = cfg_wdata; wr_sel[wr_n] = cfg_sel_glb; end
            wr_n++;
            if (cfg_sel_glb && cfg_wdata[19]) begin
                init_busy = 1'b1;
                busy_left = $urandom_range(1, 20);
            end
        end else if (init_busy && !busy_forever) begin
            if (busy_left == 0) init_busy = 1'b0;
            else busy_left--;
        end
    end

    function automatic int exp_size();
        int e;
        e = spd[4] + spd[5] / 2 + spd[3] + spd[17] / 2 + 3;
        if (e < 20 || e - 20 >= 16) return 0;
        return 1 << (e - 20);
    endfunction

    function automatic logic [31:0] exp_mod();
        int w, t, b18;
        w = (int'(spd[4]) - 8) & 7;
        w |= 1 << 3;
        w |= ((int'(spd[3]) - 11) & 3) << 4;
        w |= ((spd[17] / 4) & 1) << 6;
        w |= ((spd[5] / 2) & 1) << 7;
        w |= (((int'(spd[27]) + 9) / 10 - 1) & 3) << 8;
        t = (spd[29] > spd[28]) ? int'(spd[29]) : int'(spd[28]);
        w |= (((t + 9) / 10 - 1) & 3) << 10;
        t = (int'(spd[30]) - int'(spd[29])) & 255;
        w |= (((t + 9) / 10 - 2) & 3) << 12;
        b18 = spd[18];
        if (b18 & 8)      w |= 3 << 14;
        else if (b18 & 4) w |= 2 << 14;
        else if (b18 & 1) w |= 1 << 14;
        w |= ((exp_size() / 16 - 1) & 127) << 16;
        return 32'(w);
    endfunction

    task automatic gen_module(input bit f100);
        for (int i = 0; i < 128; i++) spd[i] = 8'($urandom_range(0, 255));
        if (f100) spd[126] = 8'd100;
        else begin
            spd[126] = 8'($urandom_range(101, 255));
            spd[9]   = 8'($urandom_range(0, 8'h75));
        end
        spd[4]  = 8'($urandom_range(8, 11));
        spd[3]  = 8'($urandom_range(11, 13));
        spd[5]  = 8'($urandom_range(1, 2));
        spd[17] = ($urandom_range(0, 1) != 0) ? 8'd4 : 8'd2;
        spd[21] = 8'($urandom_range(0, 1));
        spd[11] = ($urandom_range(0, 1) != 0) ? 8'd2 : 8'd0;
        spd[27] = 8'($urandom_range(10, 40));
        spd[28] = 8'($urandom_range(10, 60));
        spd[29] = 8'($urandom_range(10, 40));
        spd[30] = 8'(int'(spd[29]) + $urandom_range(20, 50));
    endtask

    task automatic run_check(input string ctx, input bit dbl);
        logic [7:0] exp_rd [32];
        int  exp_rn, esp, nw, wi;
        bit  det_ok, fail_rd, all_ok, ecc, exp_done;
        logic [31:0] base;
        exp_rd[0] = 8'd126; exp_rn = 1; esp = 0; det_ok = 0;
        fail_rd = (nack_sub == 126);
        if (!fail_rd) begin
            if (spd[126] == 8'd100) begin esp = 100; det_ok = 1; end
            else begin
                exp_rd[1] = 8'd9; exp_rn = 2; fail_rd = (nack_sub == 9);
                if (!fail_rd && spd[9] <= 8'h75) begin esp = 133; det_ok = 1; end
            end
        end
        if (det_ok) for (int k = 0; k < 12; k++) begin
            exp_rd[exp_rn] = 8'(TBL[k]); exp_rn++;
            if (nack_sub == TBL[k]) begin fail_rd = 1; break; end
        end
        all_ok   = det_ok && !fail_rd;
        ecc      = (spd[11] == 8'd2);
        nw       = all_ok ? (ecc ? 4 : 3) : 0;
        exp_done = all_ok && !busy_forever;

        rd_n = 0; wr_n = 0; dev_bad = 0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        if (dbl) begin
            repeat (4) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;   // R11: must be ignored
        end
        for (int i = 0; i < 3000 && !(done || error); i++) @(negedge clk);

        chk({ctx, " R2 R3 R10 done/error"}, {30'd0, done, error}, {30'd0, exp_done, !exp_done});
        chk({ctx, " R1 R2 speed"}, 32'(speed_mhz), 32'(esp));
        chk({ctx, " R4 R11 R12 read count"}, 32'(rd_n), 32'(exp_rn));
        for (int k = 0; k < exp_rn && k < rd_n; k++)
            chk({ctx, " R4 R1 read order"}, 32'(rd_log[k]), 32'(exp_rd[k]));
        chk({ctx, " R1 device address"}, 32'(dev_bad), 32'd0);
        chk({ctx, " R3 R9 write count"}, 32'(wr_n), 32'(nw));
        if (all_ok && wr_n == nw) begin
            chk({ctx, " R9 module select"}, 32'(wr_sel[0]), 32'd0);
            chk({ctx, " R5 low fields"},    32'(wr_data[0][7:0]),   32'(exp_mod() & 32'hFF));
            chk({ctx, " R5 top zero"},      32'(wr_data[0][31:23]), 32'd0);
            chk({ctx, " R6 timing fields"}, 32'(wr_data[0][13:8]),  32'((exp_mod() >> 8) & 32'h3F));
            chk({ctx, " R7 cas field"},     32'(wr_data[0][15:14]), 32'((exp_mod() >> 14) & 32'h3));
            chk({ctx, " R8 size field"},    32'(wr_data[0][22:16]), 32'((exp_mod() >> 16) & 32'h7F));
            chk({ctx, " R8 size_mb"},       32'(size_mb), 32'(exp_size()));
            chk({ctx, " R9 global default"}, wr_data[1], 32'h0222_59F1);
            wi = 2;
            if (ecc) begin chk({ctx, " R9 ecc word"}, wr_data[2], 32'h0223_59F1); wi = 3; end
            base = ecc ? 32'h0223_59F1 : 32'h0222_59F1;
            chk({ctx, " R9 init word"}, wr_data[wi], (base & ~32'h0004_0000) | 32'h0008_0000);
            chk({ctx, " R9 global select"}, 32'({wr_sel[1], wr_sel[wi]}), 32'd3);
        end
        repeat (5) @(negedge clk);
        chk({ctx, " R11 result held"}, {30'd0, done, error}, {30'd0, exp_done, !exp_done});
        busy_forever = 0; init_busy = 1'b0; nack_sub = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) spd[i] = 8'd0;
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {28'd0, done, error, rd_req, cfg_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R7: 100 MHz, ECC, CAS bit 3 wins
        gen_module(1); spd[11] = 8'd2; spd[18] = 8'h0D;
        run_check("f100_ecc_cas3", 0);
        // R2 R7: 133 at byte-9 limit, no ECC, CAS bit 2
        gen_module(0); spd[9] = 8'h75; spd[11] = 8'd0; spd[18] = 8'h05;
        run_check("f133_edge_cas2", 0);
        // R7: bit 0 only, then none
        gen_module(1); spd[18] = 8'h03; run_check("cas1", 0);
        gen_module(0); spd[18] = 8'h02; run_check("cas0", 0);
        // R8: smallest size (8 MB) wraps the size field
        gen_module(1); spd[4] = 8'd8; spd[3] = 8'd11; spd[5] = 8'd1; spd[17] = 8'd2;
        run_check("size8", 0);
        // R2: byte 9 just too slow
        gen_module(0); spd[9] = 8'h76; run_check("slow_fail", 0);
        // R3: first read not acknowledged, then a table read not acknowledged
        gen_module(1); nack_sub = 126; run_check("nack_freq", 0);
        gen_module(0); nack_sub = 27;  run_check("nack_tbl", 0);
        // R10: busy never clears
        gen_module(1); busy_forever = 1; run_check("timeout", 0);
        // R11: second start while running has no effect
        gen_module(0); run_check("dbl_start", 1);
        // Random modules
        for (int r = 0; r < 8; r++) begin
            gen_module($urandom_range(0, 1) != 0);
            run_check("random", 0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule